// File: doc/BRIEF.md
# Partitioned SIMD Saturating Adder

This block adds or subtracts two 64-bit packed operands as a vector of narrower integers. One byte-sliced carry chain spans the whole word. A lane-size select cuts that chain so each lane is computed on its own. The lanes can be eight bytes, four halfwords or two words. Every lane uses the same operation, which is addition or subtraction. Subtraction feeds the inverted second operand with a carry-in of one at the bottom of each lane.

The operands can be read as signed or as unsigned. Each lane reports overflow on its own. When saturation is enabled, a lane that overflows is clamped to the nearest representable extreme instead of wrapping. A media pipeline would place it in an execute stage. The packed result and the overflow vector are registered once and appear one clock after the operands are presented.

Top module: `simd_sat_adder`

## Requirements
- R1: While `rst_n` is low, `sum_o` and `ovf_o` are zero. Otherwise both outputs reflect the inputs sampled at the previous rising clock edge.
- R2: The `lane_sel` encoding is as follows: 2'b00 gives eight 8-bit lanes, 2'b01 gives four 16-bit lanes, and both 2'b10 and 2'b11 give two 32-bit lanes. Lane k occupies result bits [k*w +: w]. No carry or borrow passes from one lane into the next.
- R3: With `sat_en` low, each lane holds (a + b) mod 2^w when `sub_en` is 0, and (a - b) mod 2^w when `sub_en` is 1.
- R4: In signed addition (`signed_en`=1, `sub_en`=0), a lane overflows exactly when both operands have the same sign and the wrapped result has the other sign. Operands of opposite sign never overflow.
- R5: In signed subtraction, a lane overflows only when the operand signs differ. A negative minus a positive overflows when the wrapped result sign is 0. A positive minus a negative overflows when the wrapped result sign is 1.
- R6: In unsigned mode, an add overflows on a carry out of the lane's top bit. A subtract overflows when b > a, which is a borrow.
- R7: With `sat_en`=1 in signed mode, a lane that overflows toward positive becomes 0111...1. A lane that overflows toward negative becomes 1000...0.
- R8: With `sat_en`=1 in unsigned mode, an add that overflows becomes all ones and a subtract that borrows becomes zero.
- R9: `ovf_o[k]` is the overflow of lane k and is reported whatever the value of `sat_en`. In 16-bit mode `ovf_o[7:4]` reads zero, and in 32-bit mode `ovf_o[7:2]` reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 64 | Packed first operand |
| op_b | input | 64 | Packed second operand |
| lane_sel | input | 2 | Lane size: 00 byte, 01 halfword, 1x word |
| sat_en | input | 1 | 1 = clamp overflowing lanes, 0 = wrap |
| signed_en | input | 1 | 1 = two's-complement lanes, 0 = unsigned |
| sub_en | input | 1 | 1 = a minus b, 0 = a plus b |
| sum_o | output | 64 | Registered packed result |
| ovf_o | output | 8 | Registered per-lane overflow flags |

## Verification
The hardest case to reach is an overflow in a 32-bit lane that is caused by a carry rippling up through three lower byte slices. Only long runs of 0xFF or 0x00 bytes produce it, and uniformly random words almost never contain such runs. The random stimulus therefore builds each operand byte by byte, drawing heavily from 0x00, 0x7F, 0x80 and 0xFF. This creates long propagate chains that end exactly at the lane's sign bit. Directed vectors add all-ones plus one in every lane size, which proves that the chain is cut at each boundary.

// File: rtl/simd_add_pkg.sv
`timescale 1ns/1ps
package simd_add_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    LANE_B8   = 2'b00,
    LANE_B16  = 2'b01,
    LANE_B32  = 2'b10,
    LANE_B32X = 2'b11
  } lane_size_e;

  // number of byte slices that make up one lane
  function automatic int lane_span(lane_size_e s);
    case (s)
      LANE_B8:  lane_span = 1;
      LANE_B16: lane_span = 2;
      default:  lane_span = 4;
    endcase
  endfunction
endpackage

// File: rtl/simd_lane_map.sv
`timescale 1ns/1ps
module simd_lane_map
  import simd_add_pkg::*;
#(
  parameter int NUM_BYTES = 8,
  localparam int IDXW = $clog2(NUM_BYTES)
) (
  input  lane_size_e                      size_i,
  output logic [NUM_BYTES-1:0]            first_o,
  output logic [NUM_BYTES-1:0][IDXW-1:0]  top_o
);
  always_comb begin
    int span;
    span = lane_span(size_i);
    for (int i = 0; i < NUM_BYTES; i++) begin
      first_o[i] = ((i & (span - 1)) == 0);
      top_o[i]   = IDXW'(i | (span - 1));
    end
  end
endmodule

// File: rtl/simd_carry_chain.sv
`timescale 1ns/1ps
module simd_carry_chain #(
  parameter int NUM_BYTES = 8,
  parameter int BYTE_W    = 8,
  localparam int DW = NUM_BYTES * BYTE_W
) (
  input  logic [DW-1:0]        a_i,
  input  logic [DW-1:0]        b_i,
  input  logic [NUM_BYTES-1:0] first_i,
  input  logic                 lane_cin_i,
  output logic [DW-1:0]        sum_o,
  output logic [NUM_BYTES-1:0] cout_o
);
  always_comb begin
    logic c;
    logic cin;
    logic [BYTE_W:0] t;
    c = 1'b0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      cin = first_i[i] ? lane_cin_i : c;
      t = {1'b0, a_i[i*BYTE_W +: BYTE_W]} + {1'b0, b_i[i*BYTE_W +: BYTE_W]}
        + {{BYTE_W{1'b0}}, cin};
      sum_o[i*BYTE_W +: BYTE_W] = t[BYTE_W-1:0];
      c = t[BYTE_W];
      cout_o[i] = c;
    end
  end
endmodule

// File: rtl/simd_lane_judge.sv
`timescale 1ns/1ps
module simd_lane_judge #(
  parameter int BYTE_W = 8
) (
  input  logic              a_msb_i,
  input  logic              b_msb_i,
  input  logic              r_msb_i,
  input  logic              cout_i,
  input  logic              is_sub_i,
  input  logic              is_signed_i,
  output logic              ovf_o,
  output logic [BYTE_W-1:0] clamp_top_o,
  output logic [BYTE_W-1:0] clamp_low_o
);
  always_comb begin
    if (is_signed_i) begin
      if (is_sub_i) ovf_o = (a_msb_i != b_msb_i) && (r_msb_i != a_msb_i);
      else          ovf_o = (a_msb_i == b_msb_i) && (r_msb_i != a_msb_i);
      // overflow direction follows the sign of the first operand
      clamp_top_o = a_msb_i ? {1'b1, {(BYTE_W-1){1'b0}}} : {1'b0, {(BYTE_W-1){1'b1}}};
      clamp_low_o = a_msb_i ? {BYTE_W{1'b0}} : {BYTE_W{1'b1}};
    end else begin
      ovf_o       = is_sub_i ? !cout_i : cout_i;
      clamp_top_o = is_sub_i ? {BYTE_W{1'b0}} : {BYTE_W{1'b1}};
      clamp_low_o = clamp_top_o;
    end
  end
endmodule

// File: rtl/simd_sat_adder.sv
`timescale 1ns/1ps
module simd_sat_adder
  import simd_add_pkg::*;
#(
  parameter int NUM_BYTES = 8,
  localparam int DW   = NUM_BYTES * BYTE_W,
  localparam int IDXW = $clog2(NUM_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        op_a,
  input  logic [DW-1:0]        op_b,
  input  logic [1:0]           lane_sel,
  input  logic                 sat_en,
  input  logic                 signed_en,
  input  logic                 sub_en,
  output logic [DW-1:0]        sum_o,
  output logic [NUM_BYTES-1:0] ovf_o
);
  lane_size_e                      size;
  logic [NUM_BYTES-1:0]            first;
  logic [NUM_BYTES-1:0][IDXW-1:0]  top;
  logic [DW-1:0]                   b_eff;
  logic [DW-1:0]                   raw_sum;
  logic [NUM_BYTES-1:0]            cout;
  logic [NUM_BYTES-1:0]            byte_ovf;
  logic [NUM_BYTES-1:0][BYTE_W-1:0] clamp_top;
  logic [NUM_BYTES-1:0][BYTE_W-1:0] clamp_low;
  logic [DW-1:0]                   sum_n;
  logic [NUM_BYTES-1:0]            ovf_n;

  assign size  = lane_size_e'(lane_sel);
  assign b_eff = sub_en ? ~op_b : op_b;

  simd_lane_map #(.NUM_BYTES(NUM_BYTES)) u_map (
    .size_i (size),
    .first_o(first),
    .top_o  (top)
  );

  simd_carry_chain #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_chain (
    .a_i       (op_a),
    .b_i       (b_eff),
    .first_i   (first),
    .lane_cin_i(sub_en),
    .sum_o     (raw_sum),
    .cout_o    (cout)
  );

  // one judge per byte slice; only the slice at a lane's top is consulted
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_judge
    simd_lane_judge #(.BYTE_W(BYTE_W)) u_judge (
      .a_msb_i    (op_a[g*BYTE_W + BYTE_W-1]),
      .b_msb_i    (op_b[g*BYTE_W + BYTE_W-1]),
      .r_msb_i    (raw_sum[g*BYTE_W + BYTE_W-1]),
      .cout_i     (cout[g]),
      .is_sub_i   (sub_en),
      .is_signed_i(signed_en),
      .ovf_o      (byte_ovf[g]),
      .clamp_top_o(clamp_top[g]),
      .clamp_low_o(clamp_low[g])
    );
  end

  always_comb begin
    logic [IDXW-1:0] t;
    for (int i = 0; i < NUM_BYTES; i++) begin
      t = top[i];
      if (sat_en && byte_ovf[t])
        sum_n[i*BYTE_W +: BYTE_W] = (IDXW'(i) == t) ? clamp_top[t] : clamp_low[t];
      else
        sum_n[i*BYTE_W +: BYTE_W] = raw_sum[i*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    int span;
    int idx;
    span = lane_span(size);
    for (int k = 0; k < NUM_BYTES; k++) begin
      idx = k * span + span - 1;
      ovf_n[k] = (idx < NUM_BYTES) ? byte_ovf[idx[IDXW-1:0]] : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_o <= '0;
      ovf_o <= '0;
    end else begin
      sum_o <= sum_n;
      ovf_o <= ovf_n;
    end
  end
endmodule

// File: rtl/simd_sat_adder_chk.sv
`timescale 1ns/1ps
module simd_sat_adder_chk #(
  parameter int NUM_BYTES = 8,
  localparam int DW = NUM_BYTES * 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [DW-1:0]        op_a,
  input logic [DW-1:0]        op_b,
  input logic [1:0]           lane_sel,
  input logic                 sat_en,
  input logic                 signed_en,
  input logic                 sub_en,
  input logic [DW-1:0]        sum_o,
  input logic [NUM_BYTES-1:0] ovf_o
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> (sum_o == '0 && ovf_o == '0));

  // R9
  flag_unused16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(lane_sel) == 2'b01 |-> ovf_o[NUM_BYTES-1:NUM_BYTES/2] == '0);

  // R9
  flag_unused32_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(lane_sel[1]) |-> ovf_o[NUM_BYTES-1:NUM_BYTES/4] == '0);

  // R4
  opp_sign_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(lane_sel == 2'b00 && signed_en && !sub_en && (op_a[7] != op_b[7]))
    |-> !ovf_o[0]);

  // R5
  same_sign_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(lane_sel == 2'b00 && signed_en && sub_en && (op_a[7] == op_b[7]))
    |-> !ovf_o[0]);

  // R8
  usat_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(lane_sel == 2'b00 && sat_en && !signed_en && !sub_en) && ovf_o[0]
    |-> sum_o[7:0] == 8'hFF);

  // R3
  wrap_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(lane_sel == 2'b00 && !sat_en && !sub_en)
    |-> sum_o[DW-1:DW-8] == $past(op_a[DW-1:DW-8]) + $past(op_b[DW-1:DW-8]));
endmodule

bind simd_sat_adder simd_sat_adder_chk #(.NUM_BYTES(NUM_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .lane_sel(lane_sel),
  .sat_en(sat_en), .signed_en(signed_en), .sub_en(sub_en),
  .sum_o(sum_o), .ovf_o(ovf_o)
);

// File: tb/sim_simd_sat_adder.sv
`timescale 1ns/1ps
module sim_simd_sat_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [63:0] op_a = '0, op_b = '0;
  logic [1:0]  lane_sel = '0;
  logic        sat_en = 0, signed_en = 0, sub_en = 0;
  logic [63:0] sum_o;
  logic [7:0]  ovf_o;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  simd_sat_adder u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .lane_sel(lane_sel),
    .sat_en(sat_en), .signed_en(signed_en), .sub_en(sub_en),
    .sum_o(sum_o), .ovf_o(ovf_o)
  );

  function automatic void ref_calc(input logic [63:0] a, input logic [63:0] b,
                                   input logic [1:0] ls, input logic sat,
                                   input logic sg, input logic sub,
                                   output logic [63:0] r, output logic [7:0] f);
    int w;
    longint ua, ub, x, umax, smax, smin;
    logic ov;
    logic [63:0] mask;
    w = (ls == 2'b00) ? 8 : (ls == 2'b01) ? 16 : 32;
    mask = (64'd1 << w) - 64'd1;
    umax = (longint'(1) << w) - 1;
    smax = (longint'(1) << (w - 1)) - 1;
    smin = -(longint'(1) << (w - 1));
    r = '0;
    f = '0;
    for (int k = 0; k < 64 / w; k++) begin
      ua = longint'((a >> (k * w)) & mask);
      ub = longint'((b >> (k * w)) & mask);
      if (sg) begin
        if (ua > smax) ua = ua - (longint'(1) << w);
        if (ub > smax) ub = ub - (longint'(1) << w);
      end
      x = sub ? ua - ub : ua + ub;
      ov = sg ? (x > smax || x < smin) : (x < 0 || x > umax);
      if (ov && sat) x = sg ? ((x > smax) ? smax : smin) : ((x < 0) ? 0 : umax);
      r = r | ((64'(x) & mask) << (k * w));
      f[k] = ov;
    end
  endfunction

  task automatic run(input logic [63:0] a, input logic [63:0] b, input logic [1:0] ls,
                     input logic sat, input logic sg, input logic sub, input string tag);
    logic [63:0] er;
    logic [7:0]  ef;
    ref_calc(a, b, ls, sat, sg, sub, er, ef);
    @(negedge clk);
    op_a = a; op_b = b; lane_sel = ls; sat_en = sat; signed_en = sg; sub_en = sub;
    @(negedge clk);
    checks++;
    if (sum_o !== er) begin
      errors++;
      $display("FAIL %s result a=%h b=%h ls=%0d sat=%0b sg=%0b sub=%0b actual=%h expected=%h",
               tag, a, b, ls, sat, sg, sub, sum_o, er);
    end
    checks++;
    if (ovf_o !== ef) begin
      errors++;
      $display("FAIL R9/%s flags a=%h b=%h ls=%0d actual=%b expected=%b",
               tag, a, b, ls, ovf_o, ef);
    end
  endtask

  function automatic logic [63:0] rand_op();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) begin
      case ($urandom % 6)
        0: v[i*8 +: 8] = 8'h00;
        1: v[i*8 +: 8] = 8'h7F;
        2: v[i*8 +: 8] = 8'h80;
        3: v[i*8 +: 8] = 8'hFF;
        default: v[i*8 +: 8] = 8'($urandom);
      endcase
    end
    return v;
  endfunction

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    op_a = 64'hDEAD_BEEF_0123_4567;
    op_b = 64'hFFFF_FFFF_FFFF_FFFF;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero in reset
    checks++;
    if (sum_o !== 64'h0 || ovf_o !== 8'h0) begin
      errors++;
      $display("FAIL R1 reset actual=%h/%b expected=0/0", sum_o, ovf_o);
    end
    rst_n = 1'b1;

    // R2: chain is cut at every lane boundary, 11 behaves as 10
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b00, 0, 0, 0, "R2_b8");
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 2'b01, 0, 0, 0, "R2_b16");
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'b10, 0, 0, 0, "R2_b32");
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'b11, 0, 0, 0, "R2_b32x");
    run(64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 2'b10, 0, 0, 1, "R2_borrow");
    // R3: wrap mode
    run(64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_F0F0_F0F0, 2'b01, 0, 0, 1, "R3");
    // R4: signed add, same and opposite sign
    run(64'h7F7F_8080_7F80_0505, 64'h0101_FFFF_807F_0303, 2'b00, 0, 1, 0, "R4");
    // R5: signed subtract both directions
    run(64'h807F_0580_7FFF_0000, 64'h01FF_03FF_8001_8000, 2'b00, 0, 1, 1, "R5");
    // R6: unsigned carry and borrow
    run(64'hFFFF_0000_8000_0001, 64'h0001_0001_8000_0002, 2'b01, 0, 0, 1, "R6_sub");
    run(64'hFFFF_FFFF_8000_0000, 64'h0000_0001_8000_0000, 2'b10, 0, 0, 0, "R6_add");
    // R7: signed clamps
    run(64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF, 2'b10, 1, 1, 0, "R7_add");
    run(64'h7F80_7F80_7F80_7F80, 64'h8001_8001_8001_8001, 2'b00, 1, 1, 1, "R7_sub");
    // R8: unsigned clamps
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b00, 1, 0, 0, "R8_add");
    run(64'h0000_0005_0000_0000, 64'h0000_0003_0000_0001, 2'b10, 1, 0, 1, "R8_sub");
    // R9: every lane overflows, flags show unused bits as zero
    run(64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 2'b01, 0, 0, 0, "R9_b16");
    run(64'h8000_0000_8000_0000, 64'h8000_0000_8000_0000, 2'b11, 1, 1, 0, "R9_b32");

    for (int n = 0; n < 4000; n++) begin
      logic [1:0] ls;
      logic s, g, d;
      ls = 2'($urandom);
      s = 1'($urandom); g = 1'($urandom); d = 1'($urandom);
      run(rand_op(), rand_op(), ls, s, g, d,
          s ? (g ? "R7_rand" : "R8_rand") : (g ? "R4R5_rand" : "R3R6_rand"));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule